// File: doc/BRIEF.md
# Keyboard serial frame receiver

This block takes the two open-drain lines of a serial keyboard link, clock and data, and turns each 11-bit device-to-host frame into one byte. Both lines pass through two-flop synchronisers. A bit is taken whenever a falling edge shows up on the synchronised clock. The block assembles the least-significant-first data bits into a byte and checks odd parity over the data and parity bits. It then presents the result on one of two byte outputs, each with a one-cycle valid strobe.

The host gates the device with `rxEnable`. While this input is low, the block pulls the clock line low, which stops the device from sending. It also throws away any partial frame, so every new reception starts from bit zero. `rxMode` chooses where a finished byte goes: to the scancode output, to the command-answer output, or nowhere. A frame whose parity fails is still delivered, but it carries the byte 0xFE, which a command layer reads as "resend". A frame whose stop bit is wrong is not delivered at all and only raises a framing-error pulse. If the clock line stays quiet for too long in the middle of a frame, a watchdog drops the partial frame.

Top module: `keylink_rx`

## Requirements
- R1: A frame is a low start bit, then eight data bits with the least significant bit first, then an odd parity bit, then a stop bit. Each bit is sampled on a falling edge of the synchronised clock line. The byte is delivered with its bits in normal order.
- R2: If the data bits plus the parity bit hold an odd number of ones, the received byte is delivered unchanged and `parityErr` stays low.
- R3: If that count of ones is even, the byte 0xFE is delivered instead, and `parityErr` pulses high in the same cycle as the valid strobe.
- R4: A stop bit sampled low pulses `frameErr` for one cycle. That frame produces no valid strobe on either output.
- R5: `rxMode` is sampled when a frame completes. 2'b01 delivers the byte on `keyCode`/`keyValid`. 2'b10 delivers it on `answerCode`/`answerValid`. 2'b00 and 2'b11 discard it, and neither valid rises.
- R6: `lineClkHold` goes high (hold the clock line low) one cycle after `rxEnable` is low, and it is high during reset. It goes low one cycle after `rxEnable` is high.
- R7: Pulling `rxEnable` low part-way through a frame discards the bits received so far. The next complete frame after re-enabling is received correctly.
- R8: If no falling clock edge arrives for `TIMEOUT_CYCLES` cycles part-way through a frame, the partial frame is dropped. The next complete frame is received correctly.
- R9: A falling clock edge with the data line high while no frame is in progress does not start a frame.
- R10: A valid strobe is high for exactly one cycle. It rises at the third rising system-clock edge after the clock line falls for the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | High lets the device transmit. Low inhibits it and clears the partial frame |
| rxMode | input | 2 | Delivery target: 01 scancode, 10 command answer, 00/11 discard |
| lineClkIn | input | 1 | Sensed level of the clock line |
| lineDatIn | input | 1 | Sensed level of the data line |
| lineClkHold | output | 1 | High enables the open-drain pull-down on the clock line |
| keyCode | output | 8 | Last scancode byte |
| keyValid | output | 1 | One-cycle strobe for keyCode |
| answerCode | output | 8 | Last command-answer byte |
| answerValid | output | 1 | One-cycle strobe for answerCode |
| parityErr | output | 1 | One-cycle pulse: the frame just completed failed parity |
| frameErr | output | 1 | One-cycle pulse: the frame just completed had a low stop bit |

## Verification
Byte results and error pulses become visible three rising system-clock edges after the bench drops the clock line for the stop bit. That delay is two synchroniser stages plus the output register. One directed check samples at the falling system-clock edge after the second rising edge and again after the third, so it catches both an early strobe and one that lasts too long. All other results are collected by a monitor that runs on falling system-clock edges, which is half a cycle away from the edges where outputs change. It counts each one-cycle strobe and latches its byte, and the checks compare those counts and bytes once a frame has been fully driven. `lineClkHold` is due one cycle after `rxEnable` changes and is sampled at the next falling system-clock edge.

// File: rtl/keylink_pkg.sv
package keylink_pkg;

  localparam int KL_BYTE_W   = 8;
  localparam int KL_LAST_BIT = 10;
  localparam int KL_CNT_W    = $clog2(KL_LAST_BIT + 1);
  localparam logic [KL_BYTE_W-1:0] KL_RESEND_BYTE = 8'hFE;

  typedef enum logic [1:0] {
    MODE_DROP   = 2'b00,
    MODE_KEY    = 2'b01,
    MODE_ANSWER = 2'b10,
    MODE_DROPX  = 2'b11
  } kl_mode_e;

  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic takeParity;
    logic finish;
  } kl_strobe_t;

endpackage

// File: rtl/keylink_ctrl.sv
module keylink_ctrl
  import keylink_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic       lineClkIn,
  input  logic       lineDatIn,
  output logic       clkHold,
  output logic       datBit,
  output kl_strobe_t strobe
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [KL_CNT_W-1:0] CNT_LAST   = KL_CNT_W'(KL_LAST_BIT);
  localparam logic [KL_CNT_W-1:0] CNT_PARITY = KL_CNT_W'(KL_LAST_BIT - 1);

  logic [1:0] clkSync;
  logic [1:0] datSync;
  logic       clkPrev;
  logic       fallSeen;
  logic       timeoutHit;
  logic [KL_CNT_W-1:0] bitCnt;
  logic [TW-1:0]       idleCnt;

  // two-flop synchronisers, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSync <= 2'b11;
      datSync <= 2'b11;
      clkPrev <= 1'b1;
    end else begin
      clkSync <= {clkSync[0], lineClkIn};
      datSync <= {datSync[0], lineDatIn};
      clkPrev <= clkSync[1];
    end
  end

  assign fallSeen   = clkPrev & ~clkSync[1];
  assign datBit     = datSync[1];
  assign timeoutHit = (bitCnt != '0) && !fallSeen && (idleCnt == IDLE_LAST);

  always_comb begin
    strobe            = '0;
    strobe.clear      = !rxEnable || timeoutHit;
    strobe.shiftIn    = rxEnable && fallSeen && (bitCnt >= KL_CNT_W'(1)) && (bitCnt <= KL_CNT_W'(8));
    strobe.takeParity = rxEnable && fallSeen && (bitCnt == CNT_PARITY);
    strobe.finish     = rxEnable && fallSeen && (bitCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
    end else if (strobe.clear) begin
      bitCnt <= '0;
    end else if (fallSeen) begin
      if (bitCnt == '0)
        bitCnt <= datBit ? '0 : KL_CNT_W'(1);
      else if (bitCnt == CNT_LAST)
        bitCnt <= '0;
      else
        bitCnt <= bitCnt + KL_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idleCnt <= '0;
    else if (bitCnt == '0 || fallSeen || timeoutHit)
      idleCnt <= '0;
    else
      idleCnt <= idleCnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      clkHold <= 1'b1;
    else
      clkHold <= !rxEnable;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_LAST);

  // R6
  hold_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> clkHold);

  // R7
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (bitCnt == '0));

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCnt != '0 && !fallSeen && idleCnt == IDLE_LAST) |=> (bitCnt == '0));

  // R9
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEnable && bitCnt == '0 && fallSeen && datBit) |=> (bitCnt == '0));

endmodule

// File: rtl/keylink_dp.sv
module keylink_dp
  import keylink_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  kl_strobe_t           strobe,
  input  logic                 datBit,
  input  logic [1:0]           rxMode,
  output logic [KL_BYTE_W-1:0] keyCode,
  output logic                 keyValid,
  output logic [KL_BYTE_W-1:0] answerCode,
  output logic                 answerValid,
  output logic                 parityErr,
  output logic                 frameErr
);

  logic [KL_BYTE_W-1:0] shiftReg;
  logic                 parBit;
  logic                 oddOk;
  logic [KL_BYTE_W-1:0] outByte;

  // LSB arrives first: shift in from the top so it ends at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.shiftIn)    shiftReg <= {datBit, shiftReg[KL_BYTE_W-1:1]};
      if (strobe.takeParity) parBit   <= datBit;
    end
  end

  assign oddOk   = ^{shiftReg, parBit};
  assign outByte = oddOk ? shiftReg : KL_RESEND_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyCode     <= '0;
      keyValid    <= 1'b0;
      answerCode  <= '0;
      answerValid <= 1'b0;
      parityErr   <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      keyValid    <= 1'b0;
      answerValid <= 1'b0;
      parityErr   <= 1'b0;
      frameErr    <= 1'b0;
      if (strobe.finish) begin
        if (!datBit) begin
          frameErr <= 1'b1;
        end else begin
          parityErr <= !oddOk;
          case (rxMode)
            MODE_KEY: begin
              keyCode  <= outByte;
              keyValid <= 1'b1;
            end
            MODE_ANSWER: begin
              answerCode  <= outByte;
              answerValid <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(keyValid && answerValid));

  // R4
  frame_err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> (!keyValid && !answerValid));

  // R3
  parity_err_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parityErr && keyValid) |-> (keyCode == KL_RESEND_BYTE));

  // R10
  key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyValid |=> !keyValid);

  // R10
  answer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    answerValid |=> !answerValid);

endmodule

// File: rtl/keylink_rx.sv
module keylink_rx
  import keylink_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic [1:0] rxMode,
  input  logic       lineClkIn,
  input  logic       lineDatIn,
  output logic       lineClkHold,
  output logic [7:0] keyCode,
  output logic       keyValid,
  output logic [7:0] answerCode,
  output logic       answerValid,
  output logic       parityErr,
  output logic       frameErr
);

  kl_strobe_t strobe;
  logic       datBit;

  keylink_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxEnable (rxEnable),
    .lineClkIn(lineClkIn),
    .lineDatIn(lineDatIn),
    .clkHold  (lineClkHold),
    .datBit   (datBit),
    .strobe   (strobe)
  );

  keylink_dp dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .datBit     (datBit),
    .rxMode     (rxMode),
    .keyCode    (keyCode),
    .keyValid   (keyValid),
    .answerCode (answerCode),
    .answerValid(answerValid),
    .parityErr  (parityErr),
    .frameErr   (frameErr)
  );

endmodule

// File: tb/keylink_rx_tb.sv
module keylink_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;
  localparam int TIMEOUT    = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxEnable = 1'b0;
  logic [1:0] rxMode = 2'b01;
  logic       lineClkIn = 1'b1;
  logic       lineDatIn = 1'b1;
  logic       lineClkHold;
  logic [7:0] keyCode;
  logic       keyValid;
  logic [7:0] answerCode;
  logic       answerValid;
  logic       parityErr;
  logic       frameErr;

  int checks = 0;
  int fails  = 0;
  int keyCnt = 0;
  int ansCnt = 0;
  int perrCnt = 0;
  int ferrCnt = 0;
  logic [7:0] lastKey = 8'h00;
  logic [7:0] lastAns = 8'h00;
  logic       lastPerr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylink_rx #(.TIMEOUT_CYCLES(TIMEOUT)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxEnable   (rxEnable),
    .rxMode     (rxMode),
    .lineClkIn  (lineClkIn),
    .lineDatIn  (lineDatIn),
    .lineClkHold(lineClkHold),
    .keyCode    (keyCode),
    .keyValid   (keyValid),
    .answerCode (answerCode),
    .answerValid(answerValid),
    .parityErr  (parityErr),
    .frameErr   (frameErr)
  );

  always @(negedge clk) begin
    if (keyValid) begin keyCnt++; lastKey = keyCode; lastPerr = parityErr; end
    if (answerValid) begin ansCnt++; lastAns = answerCode; lastPerr = parityErr; end
    if (parityErr) perrCnt++;
    if (frameErr) ferrCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic oddParBit(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] b, input bit badPar);
    return badPar ? 8'hFE : b;
  endfunction

  task automatic sendBit(input logic b);
    lineDatIn = b;
    lineClkIn = 1'b0;
    repeat (HALF_BIT) @(negedge clk);
    lineClkIn = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit badPar, input bit badStop);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit(oddParBit(b) ^ badPar);
    sendBit(!badStop);
    lineDatIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one frame with both counts and the delivered byte checked
  task automatic frameCheck(input logic [7:0] b, input bit badPar, input logic [1:0] mode, input string tag);
    int k0, a0, p0;
    k0 = keyCnt; a0 = ansCnt; p0 = perrCnt;
    rxMode = mode;
    sendFrame(b, badPar, 1'b0);
    if (mode == 2'b01) begin
      check(keyCnt == k0 + 1 && ansCnt == a0, {tag, " key strobe"}, keyCnt - k0, 1);
      check(lastKey == expByte(b, badPar), {tag, " key byte"}, lastKey, expByte(b, badPar));
    end else if (mode == 2'b10) begin
      check(ansCnt == a0 + 1 && keyCnt == k0, {tag, " answer strobe"}, ansCnt - a0, 1);
      check(lastAns == expByte(b, badPar), {tag, " answer byte"}, lastAns, expByte(b, badPar));
    end else begin
      check(keyCnt == k0 && ansCnt == a0, {tag, " discard"}, keyCnt + ansCnt - k0 - a0, 0);
    end
    check(perrCnt == p0 + (badPar ? 1 : 0), {tag, " parity flag"}, perrCnt - p0, badPar ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // reset state, R6
    check(lineClkHold == 1'b1, "R6 hold during reset", lineClkHold, 1);
    check(!keyValid && !answerValid && !parityErr && !frameErr, "R10 idle outputs after reset",
          {keyValid, answerValid, parityErr, frameErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lineClkHold == 1'b1, "R6 hold while disabled", lineClkHold, 1);
    rxEnable = 1'b1;
    @(negedge clk);
    check(lineClkHold == 1'b0, "R6 release one cycle after enable", lineClkHold, 0);
    repeat (4) @(negedge clk);

    // R1 R2 directed
    frameCheck(8'hA5, 1'b0, 2'b01, "R1 R2 A5");
    frameCheck(8'h01, 1'b0, 2'b01, "R1 LSB-first 01");
    frameCheck(8'h80, 1'b0, 2'b10, "R1 MSB 80 answer");
    frameCheck(8'h00, 1'b0, 2'b01, "R2 all zero");
    // R3 directed
    frameCheck(8'h3C, 1'b1, 2'b01, "R3 bad parity key");
    check(lastPerr == 1'b1, "R3 flag with strobe", lastPerr, 1);
    frameCheck(8'hFF, 1'b1, 2'b10, "R3 bad parity answer");
    // R5 discard modes
    frameCheck(8'h5A, 1'b0, 2'b00, "R5 mode 00");
    frameCheck(8'h5A, 1'b0, 2'b11, "R5 mode 11");

    // R4 bad stop
    begin
      int k0, f0;
      k0 = keyCnt; f0 = ferrCnt;
      rxMode = 2'b01;
      sendFrame(8'h77, 1'b0, 1'b1);
      check(ferrCnt == f0 + 1, "R4 frame error pulse", ferrCnt - f0, 1);
      check(keyCnt == k0, "R4 no strobe on bad stop", keyCnt - k0, 0);
    end

    // R10 exact timing
    begin
      logic [7:0] b;
      b = 8'h6B;
      rxMode = 2'b01;
      sendBit(1'b0);
      for (int i = 0; i < 8; i++) sendBit(b[i]);
      sendBit(oddParBit(b));
      lineDatIn = 1'b1;
      lineClkIn = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(keyValid == 1'b0, "R10 not early", keyValid, 0);
      @(posedge clk); @(negedge clk);
      check(keyValid == 1'b1 && keyCode == b, "R10 strobe on third edge", {keyValid, keyCode}, {1'b1, b});
      @(negedge clk);
      check(keyValid == 1'b0, "R10 one cycle only", keyValid, 0);
      repeat (HALF_BIT) @(negedge clk);
      lineClkIn = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
    end

    // R7 disable mid-frame
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    rxEnable = 1'b0;
    @(negedge clk);
    check(lineClkHold == 1'b1, "R6 hold one cycle after disable", lineClkHold, 1);
    repeat (5) @(negedge clk);
    rxEnable = 1'b1;
    repeat (3) @(negedge clk);
    frameCheck(8'h5A, 1'b0, 2'b01, "R7 after re-enable");

    // R8 watchdog mid-frame
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    repeat (TIMEOUT + 50) @(negedge clk);
    frameCheck(8'hC3, 1'b0, 2'b01, "R8 after timeout");

    // R9 high start bit ignored
    sendBit(1'b1);
    repeat (4) @(negedge clk);
    frameCheck(8'h81, 1'b0, 2'b01, "R9 after high start");

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      bit bad;
      logic [1:0] m;
      b = 8'($urandom);
      bad = ($urandom % 4) == 0;
      m = (($urandom % 2) == 0) ? 2'b01 : 2'b10;
      frameCheck(b, bad, m, bad ? "R3 random" : "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule